// File: doc/BRIEF.md
# Pairwise Add-Accumulate-Long Vector Unit

This block is one execution slice of a SIMD pipeline. It takes a 32-bit instruction word, a source vector and the current contents of the destination vector (the accumulator). Each pair of neighbouring source elements is added, the pair sum is widened to twice the element width, and the widened sum is added to the matching accumulator lane. Elements are 8, 16 or 32 bits wide and are read as signed or unsigned. The operation runs over either the low 64 bits of the vectors or the full 128 bits.

The block also decodes the instruction word. It extracts the 5-bit destination and source register indices that the surrounding pipeline uses to write the result back, and it flags encodings that are not allowed. A flagged operation returns the accumulator unchanged. Results come out of one register stage with a one-cycle valid strobe. The register file, permission checks and conditional execution belong to the rest of the pipeline.

Top module: `padal_unit`

## Requirements
- R1: For element width EW selected by instruction bits 19:18 (00 = 8, 01 = 16, 10 = 32), result lane k (2*EW bits wide) equals accumulator lane k plus source elements 2k and 2k+1, where element i is source bits [i*EW +: EW].
- R2: Instruction bit 7 selects how source elements are read: 0 sign-extends each element to 2*EW bits before the pair addition, 1 zero-extends it.
- R3: Instruction bit 6 selects the vector length. With 0, only the lanes inside the low 64 bits are computed and result bits 127:64 equal accumulator bits 127:64. With 1, all 128 bits are computed.
- R4: Each lane sum wraps modulo 2^(2*EW). There is no saturation, and no carry passes into the neighbouring lane.
- R5: Size field value 11 raises out_undef, and out_vec equals the accumulator input unchanged.
- R6: When bit 6 is 1 and either instruction bit 12 or instruction bit 0 is 1 (an odd register index), out_undef is raised and out_vec equals the accumulator input. Odd indices are legal when bit 6 is 0.
- R7: out_dst_idx is {instr[22], instr[15:12]} and out_src_idx is {instr[5], instr[3:0]}.
- R8: out_valid is high for exactly one cycle, in the cycle after in_valid was sampled high. After a cycle with in_valid low, out_valid is low and every other output keeps its value.
- R9: While reset is asserted, out_valid, out_undef, out_vec and both index outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| acc_vec | input | 128 | Current destination (accumulator) vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_undef | output | 1 | Encoding was illegal; result is the unchanged accumulator |
| out_dst_idx | output | 5 | Destination register index |
| out_src_idx | output | 5 | Source register index |
| out_vec | output | 128 | Updated accumulator vector |

## Verification
The result register is the only state, so any fault in it or in the logic feeding it appears on out_vec, out_undef or the index outputs in the cycle right after the operation that caused it. A wrong lane split or a wrong extension rule corrupts whole lanes. A missing mask on the 64-bit length shows up as changed upper bits, and a missing hold shows up as out_vec drifting during idle cycles. The bench runs a behavioural model beside the unit and compares every output once per clock. It covers directed extremes (all-ones operands, the minimum negative values, accumulators that wrap) and random operations that mix legal and illegal encodings.

// File: rtl/padal_pkg.sv
package padal_pkg;

   // Instruction field positions the decoder depends on
   localparam int POS_DHI   = 22;
   localparam int POS_SZ_HI = 19;
   localparam int POS_SZ_LO = 18;
   localparam int POS_VD_HI = 15;
   localparam int POS_VD_LO = 12;
   localparam int POS_UNS   = 7;
   localparam int POS_QUAD  = 6;
   localparam int POS_MHI   = 5;
   localparam int POS_VM_HI = 3;
   localparam int POS_VM_LO = 0;

   localparam int IDX_W = 5;

   typedef enum logic [1:0] {
      ESZ_8   = 2'b00,
      ESZ_16  = 2'b01,
      ESZ_32  = 2'b10,
      ESZ_RSV = 2'b11
   } elem_size_e;

   typedef struct packed {
      logic [IDX_W-1:0] dst_idx;
      logic [IDX_W-1:0] src_idx;
      elem_size_e       esize;
      logic             is_unsigned;
      logic             is_quad;
      logic             illegal;
   } pa_decode_t;

endpackage

// File: rtl/padal_decode.sv
module padal_decode
   import padal_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int NUM_SIZES = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output pa_decode_t         dec
);
   localparam int SZ_W = POS_SZ_HI - POS_SZ_LO + 1;

   if (INSTR_W <= POS_DHI) begin : g_chk_w
      $error("padal_decode: INSTR_W too small for field layout");
   end
   if (NUM_SIZES < 1 || NUM_SIZES > (1 << SZ_W)) begin : g_chk_n
      $error("padal_decode: NUM_SIZES out of range");
   end

   logic [SZ_W-1:0] sz_field;
   logic            odd_reg;
   logic            size_rsv;

   assign sz_field = instr[POS_SZ_HI:POS_SZ_LO];
   assign size_rsv = (int'(sz_field) >= NUM_SIZES);
   assign odd_reg  = instr[POS_VD_LO] | instr[POS_VM_LO];

   always_comb begin
      dec.dst_idx     = {instr[POS_DHI], instr[POS_VD_HI:POS_VD_LO]};
      dec.src_idx     = {instr[POS_MHI], instr[POS_VM_HI:POS_VM_LO]};
      dec.esize       = elem_size_e'(sz_field);
      dec.is_unsigned = instr[POS_UNS];
      dec.is_quad     = instr[POS_QUAD];
      dec.illegal     = size_rsv | (instr[POS_QUAD] & odd_reg);
   end

   logic unused_bits;
   assign unused_bits = ^{instr[INSTR_W-1:POS_DHI+1], instr[POS_DHI-1:POS_SZ_HI+1],
                          instr[POS_SZ_LO-1:POS_VD_HI+1], instr[POS_VD_LO-1:POS_UNS+1],
                          instr[POS_MHI-1:POS_VM_HI+1]};
endmodule

// File: rtl/padal_width_path.sv
module padal_width_path #(
   parameter int EW    = 8,
   parameter int VEC_W = 128
) (
   input  logic [VEC_W-1:0] src_vec,
   input  logic [VEC_W-1:0] acc_vec,
   input  logic             is_unsigned,
   output logic [VEC_W-1:0] sum_vec
);
   localparam int DW    = 2 * EW;
   localparam int LANES = VEC_W / DW;

   if (EW < 1 || (VEC_W % DW) != 0) begin : g_chk
      $error("padal_width_path: VEC_W must be a multiple of 2*EW");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [EW-1:0] el_lo, el_hi;
      logic [DW-1:0] ext_lo, ext_hi;
      logic [DW-1:0] pair_sum;

      assign el_lo    = src_vec[(2*k)*EW +: EW];
      assign el_hi    = src_vec[(2*k+1)*EW +: EW];
      assign ext_lo   = {{EW{el_lo[EW-1] & ~is_unsigned}}, el_lo};
      assign ext_hi   = {{EW{el_hi[EW-1] & ~is_unsigned}}, el_hi};
      assign pair_sum = ext_lo + ext_hi;
      assign sum_vec[k*DW +: DW] = acc_vec[k*DW +: DW] + pair_sum;
   end
endmodule

// File: rtl/padal_merge.sv
module padal_merge
   import padal_pkg::*;
#(
   parameter int VEC_W     = 128,
   parameter int NUM_SIZES = 3
) (
   input  logic [NUM_SIZES-1:0][VEC_W-1:0] per_size,
   input  logic [VEC_W-1:0]                acc_vec,
   input  pa_decode_t                      dec,
   output logic [VEC_W-1:0]                next_vec
);
   localparam int HALF_W = VEC_W / 2;

   if ((VEC_W % 2) != 0) begin : g_chk
      $error("padal_merge: VEC_W must be even");
   end

   logic [VEC_W-1:0] picked;

   always_comb begin
      picked = acc_vec;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (int'(dec.esize) == s) picked = per_size[s];
      end
   end

   always_comb begin
      if (dec.illegal) begin
         next_vec = acc_vec;
      end else if (dec.is_quad) begin
         next_vec = picked;
      end else begin
         next_vec = {acc_vec[VEC_W-1:HALF_W], picked[HALF_W-1:0]};
      end
   end
endmodule

// File: rtl/padal_unit.sv
module padal_unit
   import padal_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int VEC_W     = 128,
   parameter int BASE_EW   = 8,
   parameter int NUM_SIZES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [VEC_W-1:0]   src_vec,
   input  logic [VEC_W-1:0]   acc_vec,
   output logic               out_valid,
   output logic               out_undef,
   output logic [IDX_W-1:0]   out_dst_idx,
   output logic [IDX_W-1:0]   out_src_idx,
   output logic [VEC_W-1:0]   out_vec
);
   localparam int HALF_W = VEC_W / 2;
   localparam int MAX_EW = BASE_EW << (NUM_SIZES - 1);

   if ((HALF_W % (2 * MAX_EW)) != 0) begin : g_chk_lanes
      $error("padal_unit: half vector must hold whole widest lanes");
   end

   pa_decode_t dec;
   logic [NUM_SIZES-1:0][VEC_W-1:0] per_size;
   logic [VEC_W-1:0] next_vec;

   padal_decode #(.INSTR_W(INSTR_W), .NUM_SIZES(NUM_SIZES)) i_dec (
      .instr (instr),
      .dec   (dec)
   );

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      padal_width_path #(.EW(BASE_EW << s), .VEC_W(VEC_W)) i_path (
         .src_vec     (src_vec),
         .acc_vec     (acc_vec),
         .is_unsigned (dec.is_unsigned),
         .sum_vec     (per_size[s])
      );
   end

   padal_merge #(.VEC_W(VEC_W), .NUM_SIZES(NUM_SIZES)) i_merge (
      .per_size (per_size),
      .acc_vec  (acc_vec),
      .dec      (dec),
      .next_vec (next_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_undef   <= 1'b0;
         out_dst_idx <= '0;
         out_src_idx <= '0;
         out_vec     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_undef   <= dec.illegal;
            out_dst_idx <= dec.dst_idx;
            out_src_idx <= dec.src_idx;
            out_vec     <= next_vec;
         end
      end
   end

   // Result strobe follows the input strobe by one cycle (R8)
   p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_undef)));
   // Reserved size leaves the accumulator untouched (R5)
   p_rsv_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[POS_SZ_HI:POS_SZ_LO] == 2'b11)
      |=> (out_undef && out_vec == $past(acc_vec)));
   // Odd register index with full length is rejected (R6)
   p_odd_quad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[POS_QUAD] && (instr[POS_VD_LO] || instr[POS_VM_LO]))
      |=> (out_undef && out_vec == $past(acc_vec)));
   // Short length never disturbs the upper half (R3)
   p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[POS_QUAD])
      |=> (out_vec[VEC_W-1:HALF_W] == $past(acc_vec[VEC_W-1:HALF_W])));
   // Index fields pass straight through (R7)
   p_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_dst_idx == {$past(instr[POS_DHI]), $past(instr[POS_VD_HI:POS_VD_LO])}));
endmodule

// File: tb/test_padal_unit.sv
module test_padal_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [127:0] src_vec = '0;
   logic [127:0] acc_vec = '0;
   logic         out_valid, out_undef;
   logic [4:0]   out_dst_idx, out_src_idx;
   logic [127:0] out_vec;

   int n_tests = 0;
   int n_fail  = 0;

   logic         e_valid = 1'b0, e_undef = 1'b0;
   logic [4:0]   e_dst = '0, e_src = '0;
   logic [127:0] e_vec = '0;

   always #4 clk = ~clk;

   padal_unit i_padal_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .src_vec(src_vec), .acc_vec(acc_vec), .out_valid(out_valid),
      .out_undef(out_undef), .out_dst_idx(out_dst_idx),
      .out_src_idx(out_src_idx), .out_vec(out_vec)
   );

   function automatic logic [31:0] mk(input logic d, input logic [3:0] vd,
                                      input logic [1:0] sz, input logic uns,
                                      input logic q, input logic m,
                                      input logic [3:0] vm);
      logic [31:0] w;
      w = 32'h0;
      w[22] = d; w[19:18] = sz; w[15:12] = vd;
      w[7] = uns; w[6] = q; w[5] = m; w[3:0] = vm;
      return w;
   endfunction

   function automatic logic [127:0] model(input logic [31:0] w,
                                          input logic [127:0] s,
                                          input logic [127:0] a);
      int ew, lanes;
      longint unsigned m1, m2, x, y, acc, sum;
      logic [127:0] r;
      r = a;
      ew = 8 << w[19:18];
      lanes = (w[6] ? 128 : 64) / (2 * ew);
      m1 = (64'd1 << ew) - 1;
      m2 = (ew == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * ew)) - 1);
      for (int k = 0; k < lanes; k++) begin
         x = 64'(s >> (2 * k * ew)) & m1;
         y = 64'(s >> ((2 * k + 1) * ew)) & m1;
         if (!w[7] && x[ew-1]) x = x | ~m1;
         if (!w[7] && y[ew-1]) y = y | ~m1;
         acc = 64'(a >> (2 * k * ew)) & m2;
         sum = (acc + x + y) & m2;
         r = r & ~(128'(m2) << (2 * k * ew));
         r = r | (128'(sum) << (2 * k * ew));
      end
      return r;
   endfunction

   task automatic check_all(input string tag);
      n_tests++;
      if (out_valid !== e_valid) begin
         n_fail++; $display("FAIL %s out_valid act=%0b exp=%0b", tag, out_valid, e_valid);
      end
      n_tests++;
      if (out_undef !== e_undef) begin
         n_fail++; $display("FAIL %s out_undef act=%0b exp=%0b", tag, out_undef, e_undef);
      end
      n_tests++;
      if (out_vec !== e_vec) begin
         n_fail++; $display("FAIL %s out_vec act=%h exp=%h", tag, out_vec, e_vec);
      end
      n_tests++;
      if (out_dst_idx !== e_dst || out_src_idx !== e_src) begin
         n_fail++; $display("FAIL %s idx act=%0d/%0d exp=%0d/%0d", tag,
                            out_dst_idx, out_src_idx, e_dst, e_src);
      end
   endtask

   task automatic step(input logic v, input logic [31:0] w,
                       input logic [127:0] s, input logic [127:0] a,
                       input string tag);
      in_valid = v; instr = w; src_vec = s; acc_vec = a;
      e_valid = v;
      if (v) begin
         e_undef = (w[19:18] == 2'b11) || (w[6] && (w[12] || w[0]));
         e_vec   = e_undef ? a : model(w, s, a);
         e_dst   = {w[22], w[15:12]};
         e_src   = {w[5], w[3:0]};
      end
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R9 reset");
      rst_n = 1'b1;
      // R1 R2: signed bytes, all -1 pairs give -2 added to lane
      step(1, mk(0, 4'd2, 2'b00, 0, 1, 0, 4'd4), {16{8'hFF}}, {8{16'd10}}, "R1 R2 s8");
      // R2: unsigned bytes, 255+255=510
      step(1, mk(1, 4'd6, 2'b00, 1, 1, 1, 4'd8), {16{8'hFF}}, '0, "R2 u8");
      step(1, mk(0, 4'd0, 2'b01, 0, 1, 0, 4'd0), {8{16'h8000}}, '0, "R1 R2 s16 min");
      step(1, mk(0, 4'd0, 2'b10, 0, 1, 0, 4'd0), {4{32'h8000_0000}}, '0, "R1 R2 s32 min");
      step(1, mk(0, 4'd0, 2'b10, 1, 1, 0, 4'd0), {4{32'hFFFF_FFFF}}, {2{64'h5}}, "R1 u32");
      // R4: wrap within the lane, no carry into neighbour
      step(1, mk(0, 4'd0, 2'b00, 1, 1, 0, 4'd0), {16{8'h01}}, {8{16'hFFFF}}, "R4 wrap u8");
      step(1, mk(0, 4'd0, 2'b10, 1, 1, 0, 4'd0), {4{32'h0000_0001}},
           {2{64'hFFFF_FFFF_FFFF_FFFF}}, "R4 wrap u32");
      // R3: short length keeps the upper half
      step(1, mk(0, 4'd3, 2'b01, 0, 0, 0, 4'd5), {128{1'b1}}, {64'hDEAD_BEEF_0123_4567, 64'h0},
           "R3 short");
      // R5: reserved size
      step(1, mk(0, 4'd2, 2'b11, 0, 1, 0, 4'd2), {16{8'h11}}, {4{32'hCAFE_F00D}}, "R5 rsv");
      // R6: odd indices with full length, and odd legal when short
      step(1, mk(0, 4'd3, 2'b00, 0, 1, 0, 4'd2), {16{8'h22}}, {4{32'h1234_5678}}, "R6 odd dst");
      step(1, mk(0, 4'd2, 2'b00, 0, 1, 0, 4'd7), {16{8'h22}}, {4{32'h1234_5678}}, "R6 odd src");
      step(1, mk(1, 4'd7, 2'b00, 0, 0, 1, 4'd9), {16{8'h22}}, {4{32'h1234_5678}}, "R6 odd short");
      // R7: all index bits
      step(1, mk(1, 4'd14, 2'b01, 1, 1, 1, 4'd12), {8{16'h7FFF}}, '0, "R7 idx");
      // R8: idle cycles hold outputs, drive garbage inputs
      step(0, 32'hFFFF_FFFF, {128{1'b1}}, {128{1'b1}}, "R8 idle");
      step(0, 32'h0, '0, '0, "R8 idle2");
      step(1, mk(0, 4'd0, 2'b00, 0, 1, 0, 4'd0), '0, {4{32'h0BAD_0BAD}}, "R8 back");
      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         logic [1:0] sz;
         sz = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
         w = mk(1'($urandom), 4'($urandom), sz, 1'($urandom), 1'($urandom),
                1'($urandom), 4'($urandom));
         if (w[6] && ($urandom % 4 != 0)) begin
            w[12] = 1'b0; w[0] = 1'b0;
         end
         step(($urandom % 5) != 0, w,
              {$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom}, "R1 R2 R3 R4 rand");
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule